// File: doc/BRIEF.md
# Width-Converting FIFO with Byte Reversal and Parity

This block is a single-clock first-in first-out buffer that holds 36-bit words, each made of four 9-bit bytes. The write port and the read port are each configured as 36, 18 or 9 bits wide. Narrow writes are gathered into a full word. A full word is split into narrow reads. A word enters storage only when its last lane has been written, and it leaves storage only when its last lane has been read.

Two optional stages sit in the write path. The first overwrites the ninth bit of every byte with odd parity over the byte's eight data bits. The second reverses the byte order of each word. On the read side, an optional checker reports a per-byte parity error alongside each read. The buffer drives empty and full flags and three threshold flags: almost-empty, half-full and almost-full. A mode input selects whether the threshold flags follow the word count directly or through one extra register stage.

The widths and the modes are captured only while reset is held. They then stay fixed until the next reset.

Top module: `widthconv_fifo`

## Requirements
- R1: While reset is held and just after it is released, empty and aempty are 1, and full, hfull and afull are 0. rd_data and par_err are zero.
- R2: With both ports 36 bits wide (mode code 0), words are read in the order they were written. rd_data and par_err are registered: they change at the clock edge that accepts a read.
- R3: Port width codes are 0 for 36 bits, 1 for 18 bits, 2 for 9 bits, and 3 behaves as 36. A narrow write uses only the low 9 or 18 bits of wr_data. The first lane fills the least significant position of the word. empty stays 1 until the last lane of the word is written.
- R4: A narrow read presents the lanes of a word least significant first, zero-extended to 36 bits. The word leaves storage only with its last lane, so empty rises only after that lane is read.
- R5: With rev_en set, byte k of a written word (bits 9k+8..9k) is read back as byte 3-k.
- R6: With par_gen set, bit 8 of each byte (bits 8, 17, 26, 35) is replaced on write by the odd parity of that byte's bits 7..0.
- R7: With par_chk set, par_err bit b is 1 when the 9 bits of the byte presented in that position hold an even number of ones. The positions are: all four bytes in 36-bit mode, bits 1..0 for the lane's two bytes in 18-bit mode, and bit 0 in 9-bit mode. Unused bits are 0. With par_chk clear, par_err stays 0.
- R8: full is 1 exactly when DEPTH words are stored. A write while full is ignored and stores nothing.
- R9: A read while empty is ignored: rd_data and par_err hold, and nothing is removed.
- R10: A read and a write accepted in the same cycle leave the word count unchanged, and both take effect.
- R11: aempty is 1 when the count is at most AE_OFS. hfull is 1 when the count is at least DEPTH/2. afull is 1 when the count is at least DEPTH-AF_OFS.
- R12: With mid_comb set, the three threshold flags change in the same cycle as empty and full. With mid_comb clear, they change one clock later.
- R13: wr_mode, rd_mode, rev_en, par_gen, par_chk and mid_comb are sampled only while rst is 1. Changes to them after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| wr_mode | input | 2 | Write width code (0:36, 1:18, 2:9) |
| rd_mode | input | 2 | Read width code (0:36, 1:18, 2:9) |
| rev_en | input | 1 | Reverse the byte order of each word |
| par_gen | input | 1 | Generate odd parity on write |
| par_chk | input | 1 | Check parity on read |
| mid_comb | input | 1 | Threshold flags without the extra register stage |
| wr_en | input | 1 | Write one lane |
| wr_data | input | 36 | Write lane data, low bits used when narrow |
| rd_en | input | 1 | Read one lane |
| rd_data | output | 36 | Registered read lane, zero-extended |
| par_err | output | 4 | Registered per-byte parity error |
| empty | output | 1 | No complete word stored |
| full | output | 1 | DEPTH words stored |
| aempty | output | 1 | Count at most AE_OFS |
| hfull | output | 1 | Count at least half of DEPTH |
| afull | output | 1 | Count at least DEPTH-AF_OFS |

## Verification
A wrong packing lane or unpacking lane shows up at rd_data as swapped or duplicated bytes on the first word that crosses the port. It also moves the empty edge by one or more lanes in the very cycle it should change. A corrupted word count or pointer shows up as full, empty or a threshold flag asserting on the wrong write. It also shows up as stale or missing data during the drain that follows, which can be many cycles later in the case of an ignored write while full. A parity or reversal fault shows up at the first read after the affected write, one cycle after rd_en is accepted.

// File: rtl/widthconv_fifo.sv
module widthconv_fifo #(
  parameter int DEPTH  = 1024,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  wr_mode,
  input  logic [1:0]  rd_mode,
  input  logic        rev_en,
  input  logic        par_gen,
  input  logic        par_chk,
  input  logic        mid_comb,
  input  logic        wr_en,
  input  logic [35:0] wr_data,
  input  logic        rd_en,
  output logic [35:0] rd_data,
  output logic [3:0]  par_err,
  output logic        empty,
  output logic        full,
  output logic        aempty,
  output logic        hfull,
  output logic        afull
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0] wm_q, rm_q;
  logic rev_q, gen_q, chk_q, comb_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [1:0] wlane, rlane;
  logic [35:0] pack, wword, gword, sword, rword, lane_d;
  logic [3:0] berr, lane_e;
  logic ae_q, hf_q, af_q;
  logic [35:0] mem [DEPTH];

  function automatic logic [1:0] last_lane(input logic [1:0] m);
    return (m == 2'd1) ? 2'd1 : (m == 2'd2) ? 2'd3 : 2'd0;
  endfunction

  wire wacc    = wr_en & ~full;
  wire wcommit = wacc & (wlane == last_lane(wm_q));
  wire racc    = rd_en & ~empty;
  wire rpop    = racc & (rlane == last_lane(rm_q));

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  wire ae_c = count <= CW'(AE_OFS);
  wire hf_c = count >= CW'(DEPTH / 2);
  wire af_c = count >= CW'(DEPTH - AF_OFS);

  assign aempty = comb_q ? ae_c : ae_q;
  assign hfull  = comb_q ? hf_c : hf_q;
  assign afull  = comb_q ? af_c : af_q;

  always_ff @(posedge clk)
    if (rst) begin
      wm_q   <= wr_mode;
      rm_q   <= rd_mode;
      rev_q  <= rev_en;
      gen_q  <= par_gen;
      chk_q  <= par_chk;
      comb_q <= mid_comb;
    end

  always_comb begin
    wword = pack;
    case (wm_q)
      2'd1: if (wlane[0]) wword[35:18] = wr_data[17:0];
            else          wword[17:0]  = wr_data[17:0];
      2'd2: case (wlane)
              2'd0: wword[8:0]   = wr_data[8:0];
              2'd1: wword[17:9]  = wr_data[8:0];
              2'd2: wword[26:18] = wr_data[8:0];
              default: wword[35:27] = wr_data[8:0];
            endcase
      default: wword = wr_data;
    endcase
    gword = wword;
    for (int b = 0; b < 4; b++)
      if (gen_q) gword[b*9+8] = ~^wword[b*9 +: 8];
    sword = rev_q ? {gword[8:0], gword[17:9], gword[26:18], gword[35:27]} : gword;
  end

  assign rword = mem[rptr];

  always_comb begin
    for (int b = 0; b < 4; b++) berr[b] = ~^rword[b*9 +: 9];
    lane_d = '0;
    lane_e = '0;
    case (rm_q)
      2'd1: begin
        lane_d[17:0] = rlane[0] ? rword[35:18] : rword[17:0];
        lane_e[1:0]  = rlane[0] ? berr[3:2] : berr[1:0];
      end
      2'd2: begin
        case (rlane)
          2'd0: lane_d[8:0] = rword[8:0];
          2'd1: lane_d[8:0] = rword[17:9];
          2'd2: lane_d[8:0] = rword[26:18];
          default: lane_d[8:0] = rword[35:27];
        endcase
        lane_e[0] = berr[rlane];
      end
      default: begin
        lane_d = rword;
        lane_e = berr;
      end
    endcase
    if (!chk_q) lane_e = '0;
  end

  always_ff @(posedge clk)
    if (wcommit) mem[wptr] <= sword;

  always_ff @(posedge clk)
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      wlane   <= '0;
      rlane   <= '0;
      pack    <= '0;
      rd_data <= '0;
      par_err <= '0;
      ae_q    <= 1'b1;
      hf_q    <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      if (wacc) begin
        wlane <= wcommit ? 2'd0 : wlane + 2'd1;
        pack  <= wcommit ? '0 : wword;
      end
      if (wcommit) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (racc) begin
        rlane   <= rpop ? 2'd0 : rlane + 2'd1;
        rd_data <= lane_d;
        par_err <= lane_e;
      end
      if (rpop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wcommit, rpop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
      ae_q <= ae_c;
      hf_q <= hf_c;
      af_q <= af_c;
    end
endmodule

// File: rtl/widthconv_fifo_chk.sv
module widthconv_fifo_chk #(
  parameter int DEPTH  = 1024,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          empty,
  input logic          full,
  input logic          aempty,
  input logic          hfull,
  input logic          afull,
  input logic          chk_q,
  input logic          comb_q,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [CW-1:0] count,
  input logic [3:0]    par_err
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R8
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(wptr));

  // R9
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> $stable(rptr));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1) ||
             (count + 1'b1 == $past(count)));

  // R1
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R7
  par_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_q |-> (par_err == 4'd0));

  // R11
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    (comb_q && empty && AE_OFS >= 0) |-> (aempty && !hfull && !afull));

  // R11
  high_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (comb_q && full && AF_OFS >= 0) |-> (afull && hfull && !aempty));
endmodule

bind widthconv_fifo widthconv_fifo_chk #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .empty(empty), .full(full),
  .aempty(aempty), .hfull(hfull), .afull(afull), .chk_q(chk_q), .comb_q(comb_q),
  .wptr(wptr), .rptr(rptr), .count(count), .par_err(par_err)
);

// File: tb/widthconv_fifo_test.sv
`timescale 1ns/1ps
module widthconv_fifo_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] wr_mode = '0, rd_mode = '0;
  logic rev_en = 0, par_gen = 0, par_chk = 0, mid_comb = 1;
  logic wr_en = 0, rd_en = 0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic [3:0] par_err;
  logic empty, full, aempty, hfull, afull;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  widthconv_fifo uut (.*);

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pb(input logic [7:0] d, input bit good);
    return {good ? ~^d : ^d, d};
  endfunction
  function automatic logic [35:0] revw(input logic [35:0] w);
    return {w[8:0], w[17:9], w[26:18], w[35:27]};
  endfunction
  function automatic logic [35:0] genw(input logic [35:0] w);
    logic [35:0] r = w;
    for (int b = 0; b < 4; b++) r[b*9+8] = ~^w[b*9 +: 8];
    return r;
  endfunction

  task automatic do_reset(input logic [1:0] wm, rm, input bit rv, gn, ck, cb);
    @(negedge clk);
    rst = 1; wr_en = 0; rd_en = 0;
    wr_mode = wm; rd_mode = rm; rev_en = rv; par_gen = gn; par_chk = ck; mid_comb = cb;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask
  task automatic wr(input logic [35:0] d);
    wr_en = 1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask
  task automatic rd(output logic [35:0] q);
    rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0; q = rd_data;
  endtask
  task automatic rw(input logic [35:0] d, output logic [35:0] q);
    wr_en = 1; rd_en = 1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; q = rd_data;
  endtask

  task automatic t_reset;
    do_reset(0, 0, 0, 0, 0, 1);
    check("R1 empty", empty, 1); check("R1 aempty", aempty, 1);
    check("R1 full", full, 0); check("R1 hfull", hfull, 0); check("R1 afull", afull, 0);
    check("R1 rd_data", rd_data, 0); check("R1 par_err", par_err, 0);
  endtask

  task automatic t_basic;
    logic [35:0] q;
    do_reset(0, 0, 0, 0, 0, 1);
    wr(36'h1_2345_6789); wr(36'hA_BCDE_F012); wr(36'h3_3333_CCCC);
    rd(q); check("R2 word0", q, 36'h1_2345_6789);
    rd(q); check("R2 word1", q, 36'hA_BCDE_F012);
    rd(q); check("R2 word2", q, 36'h3_3333_CCCC);
    check("R2 empty after drain", empty, 1);
    rd(q); check("R9 rd_data hold", q, 36'h3_3333_CCCC);
    wr(36'h0_0000_0042); rd(q); check("R9 nothing removed", q, 36'h0_0000_0042);
  endtask

  task automatic t_pack9;
    logic [35:0] q;
    do_reset(2, 0, 0, 0, 0, 1);
    wr({27'h5A5A5A5, 9'h1A1}); wr({27'h7FFFFFF, 9'h0B2}); wr({27'h1234567, 9'h1C3});
    check("R3 empty before last lane", empty, 1);
    wr({27'h0, 9'h0D4});
    check("R3 commit on last lane", empty, 0);
    rd(q); check("R3 pack order", q, {9'h0D4, 9'h1C3, 9'h0B2, 9'h1A1});
  endtask

  task automatic t_pack18;
    logic [35:0] q;
    do_reset(1, 1, 0, 0, 0, 1);
    wr({18'h3FFFF, 18'h2AAAA}); check("R3 18 empty after one lane", empty, 1);
    wr({18'h00000, 18'h15555});
    rd(q); check("R4 18 lane0", q, {18'h0, 18'h2AAAA});
    check("R4 18 word held", empty, 0);
    rd(q); check("R4 18 lane1", q, {18'h0, 18'h15555});
    check("R4 18 word gone", empty, 1);
  endtask

  task automatic t_unpack9;
    logic [35:0] q;
    logic [35:0] w = {9'h123, 9'h0FE, 9'h1DC, 9'h045};
    do_reset(0, 2, 0, 0, 0, 1);
    wr(w);
    for (int i = 0; i < 4; i++) begin
      rd(q); check($sformatf("R4 9 lane%0d", i), q, {27'h0, w[i*9 +: 9]});
      check($sformatf("R4 9 empty lane%0d", i), empty, (i == 3));
    end
  endtask

  task automatic t_rev;
    logic [35:0] q;
    logic [35:0] w = {9'h111, 9'h0A2, 9'h1B3, 9'h0C4};
    do_reset(0, 0, 1, 0, 0, 1);
    wr(w); rd(q); check("R5 reversed 36", q, revw(w));
    do_reset(2, 2, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) wr({27'h0, w[i*9 +: 9]});
    for (int i = 0; i < 4; i++) begin
      rd(q); check($sformatf("R5 reversed 9 lane%0d", i), q, {27'h0, w[(3-i)*9 +: 9]});
    end
  endtask

  task automatic t_gen;
    logic [35:0] q;
    do_reset(0, 0, 0, 1, 0, 1);
    wr(36'h0_0000_0000); rd(q); check("R6 gen zeros", q, 36'h8_0402_0100);
    wr(36'hF_0F13_7A5C); rd(q); check("R6 gen mixed", q, genw(36'hF_0F13_7A5C));
  endtask

  task automatic t_chk;
    logic [35:0] q;
    logic [35:0] bad = {pb(8'h3C, 1), pb(8'h81, 0), pb(8'h07, 1), pb(8'hFF, 1)};
    logic [35:0] good = {pb(8'h55, 1), pb(8'h01, 1), pb(8'hE0, 1), pb(8'h00, 1)};
    do_reset(0, 0, 0, 0, 1, 1);
    wr(bad); wr(good);
    rd(q); check("R7 bad byte2", par_err, 4'b0100); check("R7 data kept", q, bad);
    rd(q); check("R7 good word", par_err, 4'b0000);
    do_reset(0, 2, 0, 0, 1, 1);
    wr(bad);
    for (int i = 0; i < 4; i++) begin
      rd(q); check($sformatf("R7 9 lane%0d err", i), par_err, (i == 2) ? 4'b0001 : 4'b0000);
    end
    rd(q); check("R9 hold on empty", q, {27'h0, bad[35:27]});
    check("R9 par_err hold", par_err, 0);
    do_reset(0, 0, 0, 0, 0, 1);
    wr(bad); rd(q); check("R7 check off", par_err, 0);
  endtask

  task automatic t_full;
    logic [35:0] q;
    do_reset(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 1024; i++) begin
      wr(36'(i));
      if (i == 510) check("R11 hfull at 511", hfull, 0);
      if (i == 511) check("R11 hfull at 512", hfull, 1);
      if (i == 1014) check("R11 afull at 1015", afull, 0);
      if (i == 1015) check("R11 afull at 1016", afull, 1);
      if (i == 1022) check("R8 full at 1023", full, 0);
    end
    check("R8 full at 1024", full, 1);
    wr(36'hF_FFFF_FFFF);
    check("R8 still full", full, 1);
    for (int i = 0; i < 1024; i++) begin
      rd(q); check("R8 drain", q, 36'(i));
    end
    check("R8 no extra word", empty, 1);
  endtask

  task automatic t_rw;
    logic [35:0] q;
    do_reset(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 9; i++) wr(36'(100 + i));
    check("R11 aempty at 9", aempty, 0);
    for (int i = 0; i < 5; i++) begin
      rw(36'(200 + i), q);
      check("R10 rw data", q, 36'(100 + i));
      check("R10 count kept", aempty, 0);
    end
    rd(q); check("R10 order after rw", q, 36'(105));
    check("R11 aempty at 8", aempty, 1);
  endtask

  task automatic t_lag;
    do_reset(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) wr(36'(i));
    check("R12 reg aempty at 8", aempty, 1);
    wr(36'h9);
    check("R12 reg aempty lags", aempty, 1);
    @(posedge clk); @(negedge clk);
    check("R12 reg aempty after lag", aempty, 0);
    do_reset(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 9; i++) wr(36'(i));
    check("R12 comb aempty immediate", aempty, 0);
  endtask

  task automatic t_cfg;
    logic [35:0] q;
    do_reset(0, 0, 0, 0, 0, 1);
    wr_mode = 2; rev_en = 1; par_gen = 1; par_chk = 1; rd_mode = 2;
    wr(36'h0_0000_0001);
    check("R13 width not changed", empty, 0);
    rd(q); check("R13 modes not changed", q, 36'h0_0000_0001);
    check("R13 chk not changed", par_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset; t_basic; t_pack9; t_pack18; t_unpack9; t_rev;
    t_gen; t_chk; t_full; t_rw; t_lag; t_cfg;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule